// File: doc/BRIEF.md
# Dual-Select Asynchronous SRAM Model

This block is a synthesizable model of a byte-wide asynchronous static RAM that samples its control pins on a clock. It is meant to stand in for the external memory in a controller testbench. Two chip selects of opposite polarity, an output enable and a write enable decide the operating mode. The bidirectional data pins are split into an input bus, an output bus and a drive-enable, and the model raises the drive-enable only while it is reading.

A write is open only while three conditions hold together: the active-low select is low, the active-high select is high and write enable is low. The window opens on the last of these to become true and closes on the first to become false. On every clock the model latches the address and data presented inside the window. It commits the last latched word to the array on the clock edge where the window is first seen closed. A read of the same word in that same cycle returns the new value.

The default depth is kept small for quick elaboration. Setting `ADDR_W` to 17 gives the full 128K-word part.

Top module: `sram_dual_sel`

## Requirements
- R1: While reset is asserted and on release, `standby` is 1, `dq_oe` is 0 and `dq_out` is all zeros.
- R2: If `sel_n` is 1 or `sel_hi` is 0 at a clock edge, then after that edge `standby` is 1 and `dq_oe` is 0, whatever `oe_n` and `we_n` are.
- R3: With `sel_n`=0, `sel_hi`=1, `we_n`=1 and `oe_n`=1 at an edge, then after that edge `standby` is 0, `dq_oe` is 0 and `dq_out` is zero.
- R4: With `sel_n`=0, `sel_hi`=1, `we_n`=1 and `oe_n`=0 at an edge, then after that edge `dq_oe` is 1, `standby` is 0 and `dq_out` holds the word stored at the sampled `addr`.
- R5: With `sel_n`=0, `sel_hi`=1 and `we_n`=0 at an edge, then after that edge `dq_oe` is 0 and `standby` is 0, whatever `oe_n` is.
- R6: A write window that spans several edges stores exactly one word: the `addr` and `dq_in` sampled at its last edge. Values sampled at its earlier edges are not stored.
- R7: The window ends, and its word is committed, when any one of the following happens: `we_n` rises, `sel_n` rises or `sel_hi` falls.
- R8: A read sampled at the edge where a window closes, to the address being committed, returns the newly written data.
- R9: Every one of the 2**`ADDR_W` words is independent, including address 0 and the all-ones address.
- R10: `dq_oe` is never 1 together with `standby`, and `dq_out` is zero whenever `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sel_n | input | 1 | Chip select, active low |
| sel_hi | input | 1 | Chip select, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | DATA_W | Data driven into the part by the bus |
| dq_out | output | DATA_W | Read data, zero when not driving |
| dq_oe | output | 1 | Drive enable for the shared data bus |
| standby | output | 1 | High while the part is deselected |

## Verification
The hardest situation to reach from the ports is the closing edge of a write window. The window can end through any of three different pins, and a read to the committed address can land in that very cycle. Random stimulus seldom hits each of these exactly. Directed sequences therefore hold a window open over several cycles with changing data, then close it in each of the three ways. One of those closures flips straight into a read of the same word. Biased random traffic over a small address set then mixes writes, reads and deselects, so that such closings also occur in many other orders.

// File: rtl/sram_dual_sel_pkg.sv
package sram_dual_sel_pkg;

  // Operating modes decoded from the control pins
  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_IDLE    = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } sram_mode_e;

endpackage

// File: rtl/sram_mode_dec.sv
module sram_mode_dec
  import sram_dual_sel_pkg::*;
(
  input  logic       sel_n,
  input  logic       sel_hi,
  input  logic       oe_n,
  input  logic       we_n,
  output sram_mode_e mode
);

  // Deselection dominates, then write, then read
  always_comb begin
    if (sel_n || !sel_hi) begin
      mode = MODE_STANDBY;
    end else if (!we_n) begin
      mode = MODE_WRITE;
    end else if (!oe_n) begin
      mode = MODE_READ;
    end else begin
      mode = MODE_IDLE;
    end
  end

endmodule

// File: rtl/sram_wr_window.sv
module sram_wr_window
  import sram_dual_sel_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sram_mode_e        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);

  logic              win_q, win_d;
  logic [ADDR_W-1:0] lat_addr_q, lat_addr_d;
  logic [DATA_W-1:0] lat_data_q, lat_data_d;
  logic              lat_en;

  // Window open while all three write conditions hold
  always_comb begin
    win_d      = (mode == MODE_WRITE);
    lat_en     = win_d;
    lat_addr_d = addr;
    lat_data_d = data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
    end else begin
      win_q <= win_d;
    end
  end

  // Address and data follow the bus while the window is open
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr_q <= '0;
      lat_data_q <= '0;
    end else if (lat_en) begin
      lat_addr_q <= lat_addr_d;
      lat_data_q <= lat_data_d;
    end
  end

  // Commit on the first edge that sees the window closed
  assign commit      = win_q && !win_d;
  assign commit_addr = lat_addr_q;
  assign commit_data = lat_data_q;

endmodule

// File: rtl/sram_store.sv
module sram_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              fwd_hit;

  // Storage has no reset, as a real array would
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  // A word committed at this edge is visible to a read at this edge
  always_comb begin
    fwd_hit = wr_en && (wr_addr == rd_addr);
    rd_data = fwd_hit ? wr_data : mem_q[rd_addr];
  end

endmodule

// File: rtl/sram_dual_sel.sv
module sram_dual_sel
  import sram_dual_sel_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              standby
);

  sram_mode_e        mode;
  logic              commit;
  logic [ADDR_W-1:0] commit_addr;
  logic [DATA_W-1:0] commit_data;
  logic [DATA_W-1:0] rd_data;

  logic [DATA_W-1:0] dq_out_q, dq_out_d;
  logic              dq_oe_q, dq_oe_d;
  logic              standby_q, standby_d;

  sram_mode_dec u_dec (
    .sel_n  (sel_n),
    .sel_hi (sel_hi),
    .oe_n   (oe_n),
    .we_n   (we_n),
    .mode   (mode)
  );

  sram_wr_window #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_win (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .addr        (addr),
    .data        (dq_in),
    .commit      (commit),
    .commit_addr (commit_addr),
    .commit_data (commit_data)
  );

  sram_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk     (clk),
    .wr_en   (commit),
    .wr_addr (commit_addr),
    .wr_data (commit_data),
    .rd_addr (addr),
    .rd_data (rd_data)
  );

  // Output next state: drive only in read mode
  always_comb begin
    dq_oe_d   = (mode == MODE_READ);
    standby_d = (mode == MODE_STANDBY);
    dq_out_d  = dq_oe_d ? rd_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out_q  <= '0;
      dq_oe_q   <= 1'b0;
      standby_q <= 1'b1;
    end else begin
      dq_out_q  <= dq_out_d;
      dq_oe_q   <= dq_oe_d;
      standby_q <= standby_d;
    end
  end

  assign dq_out  = dq_out_q;
  assign dq_oe   = dq_oe_q;
  assign standby = standby_q;

endmodule

// File: rtl/sram_dual_sel_chk.sv
module sram_dual_sel_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              sel_hi,
  input logic              oe_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe,
  input logic              standby
);

  logic rd_sel;
  assign rd_sel = !sel_n && sel_hi && we_n && !oe_n;

  AST_DESEL_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || !sel_hi) |=> (standby && !dq_oe)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel_hi && we_n && oe_n) |=> (!dq_oe && !standby)); // R3

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |=> (dq_oe && !standby)); // R4

  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel && $past(rd_sel) && $stable(addr)) |=> $stable(dq_out)); // R4

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel_hi && !we_n) |=> (!dq_oe && !standby)); // R5

  AST_DRIVE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !standby); // R10

  AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0)); // R10

endmodule

bind sram_dual_sel sram_dual_sel_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .sel_n   (sel_n),
  .sel_hi  (sel_hi),
  .oe_n    (oe_n),
  .we_n    (we_n),
  .addr    (addr),
  .dq_out  (dq_out),
  .dq_oe   (dq_oe),
  .standby (standby)
);

// File: tb/sram_dual_sel_tb_top.sv
`timescale 1ns/1ps
module sram_dual_sel_tb_top;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk;
  logic              rst_n;
  logic              sel_n, sel_hi, oe_n, we_n;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dq_in;
  logic [DATA_W-1:0] dq_out;
  logic              dq_oe;
  logic              standby;

  int checks = 0;
  int errors = 0;

  // Reference state built from the requirements
  logic [DATA_W-1:0] ref_mem [DEPTH];
  logic              ref_ok  [DEPTH];
  logic              ref_win;
  logic [ADDR_W-1:0] ref_la;
  logic [DATA_W-1:0] ref_ld;

  sram_dual_sel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_hi(sel_hi),
    .oe_n(oe_n), .we_n(we_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .standby(standby)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // 0 standby, 1 idle, 2 read, 3 write
  function automatic int exp_mode(input logic sn, input logic sh,
                                  input logic on, input logic wn);
    if (sn || !sh) return 0;
    if (!wn)       return 3;
    if (!on)       return 2;
    return 1;
  endfunction

  function automatic string mode_tag(input int m);
    case (m)
      0:       return "R2";
      1:       return "R3";
      2:       return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, let the edge pass, check at next negedge
  task automatic step(input logic sn, input logic sh, input logic on,
                      input logic wn, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d, input string req);
    int m;
    logic exp_oe, exp_sb, chk_data;
    logic [DATA_W-1:0] exp_d;
    sel_n = sn; sel_hi = sh; oe_n = on; we_n = wn; addr = a; dq_in = d;
    m = exp_mode(sn, sh, on, wn);
    if (ref_win && m != 3) begin
      ref_mem[ref_la] = ref_ld;
      ref_ok[ref_la]  = 1'b1;
    end
    exp_oe   = (m == 2);
    exp_sb   = (m == 0);
    chk_data = !exp_oe || ref_ok[a];
    exp_d    = exp_oe ? ref_mem[a] : '0;
    ref_win  = (m == 3);
    if (m == 3) begin
      ref_la = a;
      ref_ld = d;
    end
    @(posedge clk);
    @(negedge clk);
    check(req == "" ? mode_tag(m) : req, "standby", 32'(standby), 32'(exp_sb));
    check(req == "" ? mode_tag(m) : req, "dq_oe", 32'(dq_oe), 32'(exp_oe));
    if (chk_data)
      check(req == "" ? mode_tag(m) : req, "dq_out", 32'(dq_out), 32'(exp_d));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [ADDR_W-1:0] top;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < DEPTH; i++) begin
      ref_mem[i] = '0;
      ref_ok[i]  = 1'b0;
    end
    ref_win = 1'b0; ref_la = '0; ref_ld = '0;
    top = '1;
    rst_n = 1'b0;
    sel_n = 1'b1; sel_hi = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    addr = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", "standby", 32'(standby), 32'd1);
    check("R1", "dq_oe", 32'(dq_oe), 32'd0);
    check("R1", "dq_out", 32'(dq_out), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "dq_oe after release", 32'(dq_oe), 32'd0);

    // R2: every enable combination under each deselect form
    for (int k = 0; k < 8; k++)
      step(k[2], k[2] ? 1'b1 : 1'b0, k[0], k[1], '0, 8'h11, "R2");
    // R3: selected, no transfer
    step(1'b0, 1'b1, 1'b1, 1'b1, 10'd5, 8'h00, "R3");
    // R5, R6: long window with oe_n low and changing data
    step(1'b0, 1'b1, 1'b0, 1'b0, 10'd7, 8'hA1, "R5");
    step(1'b0, 1'b1, 1'b0, 1'b0, 10'd7, 8'hA2, "R6");
    step(1'b0, 1'b1, 1'b1, 1'b0, 10'd7, 8'hA3, "R6");
    // R7 (we_n rise) + R8: close straight into read of same word
    step(1'b0, 1'b1, 1'b0, 1'b1, 10'd7, 8'h00, "R8");
    step(1'b0, 1'b1, 1'b0, 1'b1, 10'd7, 8'h00, "R6");
    // R7: close by sel_n rising
    step(1'b0, 1'b1, 1'b1, 1'b0, 10'd9, 8'h3C, "R7");
    step(1'b1, 1'b1, 1'b1, 1'b0, 10'd9, 8'hFF, "R7");
    step(1'b0, 1'b1, 1'b0, 1'b1, 10'd9, 8'h00, "R7");
    // R7: close by sel_hi falling
    step(1'b0, 1'b1, 1'b1, 1'b0, 10'd11, 8'h5A, "R7");
    step(1'b0, 1'b0, 1'b1, 1'b0, 10'd11, 8'hEE, "R7");
    step(1'b0, 1'b1, 1'b0, 1'b1, 10'd11, 8'h00, "R7");
    // R9: both ends of the address range
    step(1'b0, 1'b1, 1'b1, 1'b0, '0, 8'h81, "R9");
    step(1'b0, 1'b1, 1'b1, 1'b1, '0, 8'h00, "R9");
    step(1'b0, 1'b1, 1'b1, 1'b0, top, 8'h7E, "R9");
    step(1'b0, 1'b1, 1'b1, 1'b1, top, 8'h00, "R9");
    step(1'b0, 1'b1, 1'b0, 1'b1, '0, 8'h00, "R9");
    step(1'b0, 1'b1, 1'b0, 1'b1, top, 8'h00, "R9");

    // Biased random traffic; R10 is covered by every step's checks
    for (int n = 0; n < 4000; n++) begin
      logic sn, sh, on, wn;
      logic [ADDR_W-1:0] a;
      sn = ($urandom_range(0, 9) == 0);
      sh = ($urandom_range(0, 9) != 0);
      on = $urandom_range(0, 1) != 0;
      wn = ($urandom_range(0, 2) != 0);
      a  = ($urandom_range(0, 7) == 0) ? ADDR_W'($urandom) : ADDR_W'($urandom_range(0, 15));
      step(sn, sh, on, wn, a, DATA_W'($urandom), "");
    end
    finish_run();
  end

endmodule